// File: doc/BRIEF.md
# TRB Ring Dequeue Engine

This block is the consumer side of a segmented circular work ring in system memory, of the kind a USB host controller walks for its command and transfer rings. Software loads a dequeue pointer and the expected cycle state, then strobes a poll input. The engine fetches 16-byte TRBs one at a time through a request/response memory read port. It decides ownership by comparing each TRB's cycle bit with its own cycle state, and it follows link TRBs to other segments.

Ordinary TRBs are gathered into a local buffer until one with a clear chain bit closes the descriptor. The whole descriptor is then emitted on a valid/ready stream, with each TRB's memory address and an end-of-descriptor marker. When the engine meets a TRB it does not own, it parks and waits for the next poll instead of re-reading memory. A chain too long for the buffer halts the engine with an error flag until software reloads the pointer.

Top module: `trb_ring_dequeue`

## Requirements
- R1: After reset the dequeue pointer and cycle state read zero, the error flag is low, no memory request and no output are presented, and the engine stays idle until a poll strobe arrives.
- R2: A memory request carries the current dequeue pointer as its address and holds valid and address steady until accepted. Only one read is outstanding at a time.
- R3: A fetched TRB whose cycle bit (bit 96) differs from the cycle state is not consumed. The pointer and cycle state stay unchanged, and the engine idles until the next poll.
- R4: An owned TRB whose type field (bits 111:106) equals 6 is a link. It is never emitted. The pointer takes bits 63:0 of the link with the low 4 bits cleared. The cycle state is inverted when bit 97 is set and kept when it is clear.
- R5: Each owned non-link TRB advances the dequeue pointer by 16.
- R6: Owned TRBs with chain bit 100 set are held back. Only when a TRB with bit 100 clear arrives is the descriptor emitted, in fetch order, each beat carrying its TRB and fetch address, and the last flag set only on the final beat.
- R7: A chain that meets link TRBs continues in the target segment as one descriptor.
- R8: If the ring runs dry in mid-chain, nothing is emitted. The held TRBs are kept, and after a later poll the chain resumes and is emitted whole once it closes.
- R9: A chain of exactly DEPTH TRBs is emitted normally. If the DEPTH-th owned TRB still has its chain bit set, the error flag rises, held TRBs are dropped and nothing is emitted. The pointer moves past that TRB, and the engine ignores polls until software writes the pointer, which also clears the flag.
- R10: While the output is valid and not accepted, valid, data, address and last flag hold steady.
- R11: Software writes of the pointer (low 4 bits cleared) and of the cycle state take effect only while the engine is idle or halted and are ignored otherwise. A pointer write drops any partially gathered chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_ptr_wr | input | 1 | Software strobe to load the dequeue pointer |
| sw_ptr_data | input | ADDR_W | New dequeue pointer value |
| sw_cyc_wr | input | 1 | Software strobe to load the cycle state |
| sw_cyc_data | input | 1 | New cycle state value |
| poll | input | 1 | Doorbell strobe that restarts fetching from idle |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of the TRB to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Returned TRB |
| out_valid | output | 1 | Descriptor beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_trb | output | 128 | TRB contents |
| out_addr | output | ADDR_W | Memory address the TRB was read from |
| out_last | output | 1 | Final TRB of the descriptor |
| deq_ptr | output | ADDR_W | Current dequeue pointer |
| cyc_state | output | 1 | Current consumer cycle state |
| chain_err | output | 1 | Chain overflowed the buffer; engine halted |

## Verification
The hardest situation to reach is a chain that is cut off by an unowned TRB after part of it has been gathered. The held entries must then survive an idle period, and the chain must pick up again after the producer fills in the missing TRB. The bench builds this by writing a two-TRB chain followed by a slot with the wrong cycle bit, polling, and checking that nothing comes out and the pointer rests on the gap. It then overwrites the gap with a closing TRB and polls again, expecting all three entries as one descriptor. The overflow halt is reached the same way, using a chain one longer than the buffer.

// File: rtl/trb_ring_pkg.sv
package trb_ring_pkg;
    localparam int TRB_W     = 128;
    localparam int TRB_BYTES = 16;
    localparam int CYC_BIT   = 96;
    localparam int TOG_BIT   = 97;
    localparam int CHAIN_BIT = 100;
    localparam int TYPE_LO   = 106;
    localparam int TYPE_W    = 6;
    localparam logic [TYPE_W-1:0] TYPE_LINK = 6'd6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DRAIN,
        ST_HALT
    } eng_state_e;
endpackage

// File: rtl/trb_field_dec.sv
module trb_field_dec
    import trb_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [TRB_W-1:0]  trb,
    output logic              cyc,
    output logic              chain,
    output logic              is_link,
    output logic              toggle,
    output logic [ADDR_W-1:0] seg_ptr
);
    always_comb begin
        cyc     = trb[CYC_BIT];
        chain   = trb[CHAIN_BIT];
        toggle  = trb[TOG_BIT];
        is_link = (trb[TYPE_LO +: TYPE_W] == TYPE_LINK);
        seg_ptr = {trb[ADDR_W-1:4], 4'b0000};
    end
endmodule

// File: rtl/trb_desc_buf.sv
module trb_desc_buf #(
    parameter int DEPTH = 8,
    parameter int W     = 192,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             rd_last,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] wr;
        logic [CNT_W-1:0] rd;
    } buf_regs_t;

    buf_regs_t d, q;
    logic [W-1:0] store_q [DEPTH];

    always_comb begin
        count   = q.wr - q.rd;
        rd_last = (count == CNT_W'(1));
        dout    = store_q[q.rd[IDX_W-1:0]];
        d       = q;
        if (clear) begin
            d.wr = '0;
            d.rd = '0;
        end else begin
            if (push) d.wr = q.wr + CNT_W'(1);
            if (pop) begin
                d.rd = q.rd + CNT_W'(1);
                if (rd_last) begin
                    d.wr = '0;
                    d.rd = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) store_q[q.wr[IDX_W-1:0]] <= din;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/trb_ring_dequeue.sv
module trb_ring_dequeue
    import trb_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DEPTH  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_ptr_wr,
    input  logic [ADDR_W-1:0]  sw_ptr_data,
    input  logic               sw_cyc_wr,
    input  logic               sw_cyc_data,
    input  logic               poll,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [TRB_W-1:0]   mem_rsp_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TRB_W-1:0]   out_trb,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_last,
    output logic [ADDR_W-1:0]  deq_ptr,
    output logic               cyc_state,
    output logic               chain_err
);
    localparam int ENT_W = ADDR_W + TRB_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(TRB_BYTES);

    typedef struct packed {
        eng_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic              ccs;
        logic              err;
    } eng_regs_t;

    eng_regs_t d, q;

    logic              f_cyc, f_chain, f_link, f_tog;
    logic [ADDR_W-1:0] f_seg;
    logic              buf_push, buf_pop, buf_clr, buf_last;
    logic [ENT_W-1:0]  buf_dout;
    logic [CNT_W-1:0]  buf_cnt;
    logic              sw_ok;

    trb_field_dec #(.ADDR_W(ADDR_W)) u_dec (
        .trb     (mem_rsp_data),
        .cyc     (f_cyc),
        .chain   (f_chain),
        .is_link (f_link),
        .toggle  (f_tog),
        .seg_ptr (f_seg)
    );

    trb_desc_buf #(.DEPTH(DEPTH), .W(ENT_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clr),
        .push    (buf_push),
        .din     ({q.ptr, mem_rsp_data}),
        .pop     (buf_pop),
        .dout    (buf_dout),
        .rd_last (buf_last),
        .count   (buf_cnt)
    );

    always_comb begin
        d        = q;
        buf_push = 1'b0;
        buf_pop  = 1'b0;
        buf_clr  = 1'b0;
        sw_ok    = (q.state == ST_IDLE) || (q.state == ST_HALT);
        case (q.state)
            ST_REQ: if (mem_req_ready) d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (f_cyc != q.ccs) begin
                        d.state = ST_IDLE;
                    end else if (f_link) begin
                        d.ptr   = f_seg;
                        d.ccs   = q.ccs ^ f_tog;
                        d.state = ST_REQ;
                    end else begin
                        d.ptr = q.ptr + STEP;
                        if (f_chain && (buf_cnt == CNT_W'(DEPTH - 1))) begin
                            d.err   = 1'b1;
                            buf_clr = 1'b1;
                            d.state = ST_HALT;
                        end else begin
                            buf_push = 1'b1;
                            d.state  = f_chain ? ST_REQ : ST_DRAIN;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (out_ready) begin
                    buf_pop = 1'b1;
                    if (buf_last) d.state = ST_REQ;
                end
            end
            default: ;
        endcase
        if (sw_ok) begin
            if (sw_ptr_wr) begin
                d.ptr   = {sw_ptr_data[ADDR_W-1:4], 4'b0000};
                d.err   = 1'b0;
                buf_clr = 1'b1;
                d.state = ST_IDLE;
            end
            if (sw_cyc_wr) d.ccs = sw_cyc_data;
            if (poll && (d.state == ST_IDLE)) d.state = ST_REQ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.ptr   <= '0;
            q.ccs   <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_req_valid = (q.state == ST_REQ);
    assign mem_req_addr  = q.ptr;
    assign out_valid     = (q.state == ST_DRAIN);
    assign out_trb       = buf_dout[TRB_W-1:0];
    assign out_addr      = buf_dout[ENT_W-1:TRB_W];
    assign out_last      = buf_last;
    assign deq_ptr       = q.ptr;
    assign cyc_state     = q.ccs;
    assign chain_err     = q.err;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R3
    unowned_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && mem_rsp_valid && f_cyc != q.ccs)
            |=> ($stable(deq_ptr) && $stable(cyc_state) && !mem_req_valid && !out_valid));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_WAIT && mem_rsp_valid && f_cyc == q.ccs && !f_link)
            |=> (deq_ptr == $past(deq_ptr) + STEP));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_trb)
            && $stable(out_addr) && $stable(out_last)));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_err && !sw_ptr_wr) |=> chain_err);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_err |-> (!mem_req_valid && !out_valid));
endmodule

// File: tb/trb_ring_dequeue_tb.sv
module trb_ring_dequeue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 64;
    localparam int DEPTH  = 8;
    localparam int MEM_N  = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_ptr_wr = 1'b0;
    logic [ADDR_W-1:0] sw_ptr_data = '0;
    logic              sw_cyc_wr = 1'b0;
    logic              sw_cyc_data = 1'b0;
    logic              poll = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid;
    logic [127:0]      mem_rsp_data;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [127:0]      out_trb;
    logic [ADDR_W-1:0] out_addr;
    logic              out_last;
    logic [ADDR_W-1:0] deq_ptr;
    logic              cyc_state;
    logic              chain_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [127:0] mem [MEM_N];
    logic [63:0]  cap_addr [64];
    logic [31:0]  cap_id   [64];
    logic         cap_last [64];
    int           n_cap = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trb_ring_dequeue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_ptr_wr(sw_ptr_wr), .sw_ptr_data(sw_ptr_data),
        .sw_cyc_wr(sw_cyc_wr), .sw_cyc_data(sw_cyc_data),
        .poll(poll),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_trb(out_trb), .out_addr(out_addr), .out_last(out_last),
        .deq_ptr(deq_ptr), .cyc_state(cyc_state), .chain_err(chain_err)
    );

    // memory model: request ready on alternate cycles, data one cycle later
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_req_ready <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            mem_req_ready <= !mem_req_ready;
            mem_rsp_valid <= mem_req_valid && mem_req_ready;
            mem_rsp_data  <= mem[mem_req_addr[10:4]];
        end
    end

    // output monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && n_cap < 64) begin
            cap_addr[n_cap] = out_addr;
            cap_id[n_cap]   = out_trb[31:0];
            cap_last[n_cap] = out_last;
            n_cap = n_cap + 1;
        end
    end

    function automatic logic [127:0] mk_trb(input logic [31:0] id, input bit cyc, input bit ch);
        logic [31:0] dw3;
        dw3 = (32'd1 << 10) | (32'(ch) << 4) | 32'(cyc);
        return {dw3, 32'h0, 32'h0, id};
    endfunction

    function automatic logic [127:0] mk_link(input logic [63:0] tgt, input bit tog, input bit cyc);
        logic [31:0] dw3;
        dw3 = (32'd6 << 10) | (32'(tog) << 1) | 32'(cyc);
        return {dw3, 32'h0, tgt};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic sw_set(input logic [63:0] p, input bit c);
        @(posedge clk); #1;
        sw_ptr_wr = 1'b1; sw_ptr_data = p; sw_cyc_wr = 1'b1; sw_cyc_data = c;
        @(posedge clk); #1;
        sw_ptr_wr = 1'b0; sw_cyc_wr = 1'b0;
    endtask

    task automatic do_poll();
        @(posedge clk); #1;
        poll = 1'b1;
        @(posedge clk); #1;
        poll = 1'b0;
    endtask

    task automatic put(input logic [63:0] a, input logic [127:0] t);
        mem[a[10:4]] = t;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(deq_ptr == 0, "R1 ptr", deq_ptr, 0);
        chk(cyc_state == 0, "R1 cycle", 64'(cyc_state), 0);
        chk(!mem_req_valid && !out_valid && !chain_err, "R1 quiet",
            {mem_req_valid, out_valid, chain_err}, 0);
        wait_cyc(10);
        chk(!mem_req_valid && n_cap == 0, "R1 idle without poll", 64'(n_cap), 0);
    endtask

    task automatic t_segments();
        put(64'h100, mk_trb(1, 1, 1));
        put(64'h110, mk_trb(2, 1, 1));
        put(64'h120, mk_link(64'h20A, 0, 1));
        put(64'h200, mk_trb(3, 1, 1));
        put(64'h210, mk_trb(4, 1, 0));
        put(64'h220, mk_link(64'h300, 0, 1));
        put(64'h300, mk_trb(5, 1, 1));
        put(64'h310, mk_trb(6, 1, 0));
        put(64'h320, mk_link(64'h10F, 1, 1));
        n_cap = 0;
        sw_set(64'h100, 1);
        do_poll();
        wait_cyc(150);
        chk(n_cap == 6, "R6 beat count", 64'(n_cap), 6);
        for (int i = 0; i < 6; i++) begin
            chk(cap_id[i] == 32'(i + 1), "R6 order", cap_id[i], 64'(i + 1));
            chk(cap_last[i] == (i == 3 || i == 5), "R6 last flag",
                64'(cap_last[i]), 64'(i == 3 || i == 5));
        end
        chk(cap_addr[1] == 64'h110, "R5 addr step", cap_addr[1], 64'h110);
        chk(cap_addr[2] == 64'h200, "R7 chain across link", cap_addr[2], 64'h200);
        chk(cap_addr[3] == 64'h210, "R7 addr in next segment", cap_addr[3], 64'h210);
        chk(cap_addr[4] == 64'h300, "R4 link target", cap_addr[4], 64'h300);
        chk(deq_ptr == 64'h100, "R4 masked link target, R3 stop", deq_ptr, 64'h100);
        chk(cyc_state == 1'b0, "R4 toggle inverts", 64'(cyc_state), 0);
    endtask

    task automatic t_empty();
        n_cap = 0;
        sw_set(64'h100, 0);
        do_poll();
        wait_cyc(30);
        chk(n_cap == 0, "R3 no output when empty", 64'(n_cap), 0);
        chk(deq_ptr == 64'h100, "R3 ptr kept", deq_ptr, 64'h100);
        chk(!mem_req_valid, "R3 waits for poll", 64'(mem_req_valid), 0);
    endtask

    task automatic t_partial();
        put(64'h400, mk_trb(32'h11, 0, 1));
        put(64'h410, mk_trb(32'h12, 0, 1));
        put(64'h420, mk_trb(0, 1, 0));
        n_cap = 0;
        sw_set(64'h400, 0);
        do_poll();
        wait_cyc(40);
        chk(n_cap == 0, "R8 partial held back", 64'(n_cap), 0);
        chk(deq_ptr == 64'h420, "R8 ptr at gap", deq_ptr, 64'h420);
        put(64'h420, mk_trb(32'h13, 0, 0));
        put(64'h430, mk_trb(0, 1, 0));
        do_poll();
        wait_cyc(40);
        chk(n_cap == 3, "R8 resumed chain", 64'(n_cap), 3);
        chk(cap_id[0] == 32'h11 && cap_id[2] == 32'h13, "R8 order", cap_id[2], 64'h13);
        chk(!cap_last[1] && cap_last[2], "R8 last flag", 64'(cap_last[2]), 1);
        chk(deq_ptr == 64'h430, "R8 final ptr", deq_ptr, 64'h430);
    endtask

    task automatic t_backpressure();
        put(64'h500, mk_trb(32'h21, 0, 0));
        put(64'h510, mk_trb(0, 1, 0));
        n_cap = 0;
        out_ready = 1'b0;
        sw_set(64'h500, 0);
        do_poll();
        wait_cyc(20);
        @(negedge clk);
        chk(out_valid && out_last, "R10 beat held", {out_valid, out_last}, 3);
        chk(out_addr == 64'h500 && out_trb[31:0] == 32'h21, "R10 data held", out_addr, 64'h500);
        @(posedge clk); #1;
        sw_ptr_wr = 1'b1; sw_ptr_data = 64'h7770;
        @(posedge clk); #1;
        sw_ptr_wr = 1'b0;
        wait_cyc(2);
        chk(deq_ptr == 64'h510, "R11 write ignored while busy", deq_ptr, 64'h510);
        out_ready = 1'b1;
        wait_cyc(20);
        chk(n_cap == 1, "R10 beat delivered once", 64'(n_cap), 1);
        chk(deq_ptr == 64'h510, "R11 ptr after drain", deq_ptr, 64'h510);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) put(64'h600 + 64'(16 * i), mk_trb(32'h30 + 32'(i), 0, 1));
        n_cap = 0;
        sw_set(64'h600, 0);
        do_poll();
        wait_cyc(80);
        chk(chain_err, "R9 error raised", 64'(chain_err), 1);
        chk(n_cap == 0, "R9 nothing emitted", 64'(n_cap), 0);
        chk(deq_ptr == 64'h680, "R9 ptr past bad TRB", deq_ptr, 64'h680);
        do_poll();
        wait_cyc(20);
        chk(deq_ptr == 64'h680 && chain_err, "R9 poll ignored in halt", deq_ptr, 64'h680);
        sw_set(64'h705, 0);
        @(negedge clk);
        chk(!chain_err, "R9 cleared by ptr write", 64'(chain_err), 0);
        chk(deq_ptr == 64'h700, "R11 ptr write masks low bits", deq_ptr, 64'h700);
    endtask

    task automatic t_exact_depth();
        for (int i = 0; i < DEPTH; i++)
            put(64'h700 + 64'(16 * i), mk_trb(32'h40 + 32'(i), 0, i != DEPTH - 1));
        put(64'h780, mk_trb(0, 1, 0));
        n_cap = 0;
        do_poll();
        wait_cyc(120);
        chk(n_cap == DEPTH, "R9 full-depth chain emitted", 64'(n_cap), 64'(DEPTH));
        chk(cap_last[DEPTH-1] && !cap_last[DEPTH-2], "R6 last on final only",
            64'(cap_last[DEPTH-1]), 1);
        chk(!chain_err && deq_ptr == 64'h780, "R9 no error at depth", deq_ptr, 64'h780);
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = mk_trb(0, 1, 0);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_segments();
        t_empty();
        t_partial();
        t_backpressure();
        t_overflow();
        t_exact_depth();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule